// File: doc/BRIEF.md
# Calendar Alarm Match and Clock Control

This block sits beside the second-to-year counter chain of a calendar clock. It keeps one alarm register for each of six calendar fields: second, minute, hour, day of week, day of month and month. Each of these registers combines a compare-enable bit with a BCD value. The year alarm is wider, so it is split across byte registers, and its enable lives in a register of its own. Each cycle the block compares the enabled alarm fields with the live counter values. A sticky alarm flag is raised when the enabled fields all agree.

The same byte-wide register bus also reaches two control registers. One holds the alarm flag and the alarm interrupt enable. The other holds a start bit, which drives the counter chain's run-enable. It also holds a self-clearing soft-reset bit. Writing that bit wipes the alarm state and pulses a divider-reset output for one cycle. Reads return data combinationally from the presented address.

Top module: `rtc_alarm_ctl`

## Requirements
- R1: For the six fields at addresses 2 (second) through 7 (month), bit 7 is the compare-enable and bits 6:0 are the alarm value. A field with its enable at 0 never blocks a match, whatever its counter holds.
- R2: Suppose at least one field is enabled and every enabled field equals its counter. Then the alarm flag (address 0, bit 0) reads 1 after the next rising clock edge.
- R3: When no field is enabled, including the year, the alarm flag is never set.
- R4: The flag stays set until a write to address 0 with bit 0 at 0. Writing 1 to bit 0 has no effect. After a clear, a match that simply persists does not set the flag again; the match must first go away and then return.
- R5: The year compare-enable is bit 7 of address 8. The year alarm value is YEAR_W bits wide, with its low byte at address 9 and its higher bytes at the addresses that follow. When the year is enabled, all YEAR_W bits must equal the year counter.
- R6: Bits 6:0 of address 8 always read 0, whatever was written to them.
- R7: Writing address 1 with bit 1 set does four things. It clears every alarm register, the year enable and the alarm flag. It drives div_rst high for exactly the one cycle after the write. Bit 1 of address 1 always reads 0.
- R8: Bit 0 of address 1 is the start bit. run_en follows it, and run_en changes only on a write to address 1.
- R9: alarm_irq is 1 exactly when the alarm flag is 1 and the interrupt enable (address 0, bit 3) is 1.
- R10: After the synchronous reset, every register reads 0 and run_en, div_rst, alarm_flag and alarm_irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_sec | input | 7 | BCD seconds counter |
| cnt_min | input | 7 | BCD minutes counter |
| cnt_hour | input | 7 | BCD hours counter |
| cnt_wday | input | 7 | Day-of-week counter |
| cnt_day | input | 7 | BCD day-of-month counter |
| cnt_mon | input | 7 | BCD month counter |
| cnt_year | input | YEAR_W | BCD year counter |
| run_en | output | 1 | Counter chain run-enable |
| div_rst | output | 1 | One-cycle prescaler reset pulse |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench sweeps all 128 combinations of enable bits over the seven fields. For each combination it starts with every counter mismatched and then brings the fields into agreement one at a time. A design that compared disabled fields would raise the flag late, and one that ignored enables would raise it early. A design that did not require at least one enable would fire on the empty mask. The year is also tested with only its upper byte wrong, which catches a compare that checks only part of the year. Directed cases cover the following. A flag that re-arms while a match persists. A write of 1 that wrongly clears the flag. A soft reset that leaves alarm state behind or holds div_rst too long. The reserved bits of the year enable register reading back nonzero.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int VAL_W   = 7;
    localparam int NUM_FLD = 6;

    // register addresses
    localparam int ADR_CTL1 = 0;
    localparam int ADR_CTL2 = 1;
    localparam int ADR_FLD0 = 2;
    localparam int ADR_YEN  = 8;
    localparam int ADR_YR0  = 9;

    // bit positions
    localparam int BIT_FLAG  = 0;
    localparam int BIT_AIE   = 3;
    localparam int BIT_START = 0;
    localparam int BIT_SRST  = 1;
    localparam int BIT_EN    = 7;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } fld_alarm_t;

    function automatic fld_alarm_t unpack_alarm(input logic [DATA_W-1:0] d);
        fld_alarm_t a;
        a.en  = d[BIT_EN];
        a.val = d[VAL_W-1:0];
        return a;
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int YEAR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  logic                            flag_in,
    output logic [DATA_W-1:0]               bus_rdata,
    output fld_alarm_t [NUM_FLD-1:0]        alm_o,
    output logic                            yen_o,
    output logic [YEAR_W-1:0]               yalm_o,
    output logic                            start_o,
    output logic                            aie_o,
    output logic                            divrst_o,
    output logic                            soft_clr_o,
    output logic                            flag_clr_o
);
    localparam int YB = YEAR_W / DATA_W;
    localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(ADR_CTL1);
    localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(ADR_CTL2);
    localparam logic [ADDR_W-1:0] A_YEN  = ADDR_W'(ADR_YEN);

    fld_alarm_t [NUM_FLD-1:0]  alm_q;
    logic [DATA_W-1:0]         ybyte_q [YB];
    logic                      yen_q, start_q, aie_q, divrst_q;
    logic                      wr_ctl1, wr_ctl2, soft_clr;

    assign wr_ctl1  = bus_wr && (bus_addr == A_CTL1);
    assign wr_ctl2  = bus_wr && (bus_addr == A_CTL2);
    assign soft_clr = wr_ctl2 && bus_wdata[BIT_SRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= 1'b0;
            aie_q    <= 1'b0;
            divrst_q <= 1'b0;
        end else begin
            divrst_q <= soft_clr;
            if (wr_ctl1) aie_q   <= bus_wdata[BIT_AIE];
            if (wr_ctl2) start_q <= bus_wdata[BIT_START];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            alm_q <= '0;
            yen_q <= 1'b0;
            for (int b = 0; b < YB; b++) ybyte_q[b] <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_FLD; i++)
                if (bus_addr == ADDR_W'(ADR_FLD0 + i)) alm_q[i] <= unpack_alarm(bus_wdata);
            for (int b = 0; b < YB; b++)
                if (bus_addr == ADDR_W'(ADR_YR0 + b)) ybyte_q[b] <= bus_wdata;
            if (bus_addr == A_YEN) yen_q <= bus_wdata[BIT_EN];
        end
    end

    genvar gb;
    generate
        for (gb = 0; gb < YB; gb++) begin : g_ybyte
            assign yalm_o[gb*DATA_W +: DATA_W] = ybyte_q[gb];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTL1) begin
            bus_rdata[BIT_FLAG] = flag_in;
            bus_rdata[BIT_AIE]  = aie_q;
        end
        if (bus_addr == A_CTL2) bus_rdata[BIT_START] = start_q;
        if (bus_addr == A_YEN)  bus_rdata[BIT_EN]    = yen_q;
        for (int i = 0; i < NUM_FLD; i++)
            if (bus_addr == ADDR_W'(ADR_FLD0 + i)) bus_rdata = alm_q[i];
        for (int b = 0; b < YB; b++)
            if (bus_addr == ADDR_W'(ADR_YR0 + b)) bus_rdata = ybyte_q[b];
    end

    assign alm_o      = alm_q;
    assign yen_o      = yen_q;
    assign start_o    = start_q;
    assign aie_o      = aie_q;
    assign divrst_o   = divrst_q;
    assign soft_clr_o = soft_clr;
    assign flag_clr_o = wr_ctl1 && !bus_wdata[BIT_FLAG];

    AST_SOFT_CLEARS_ALARMS: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (alm_q == '0) && !yen_q && (yalm_o == '0)); // R7
    AST_DIVRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        divrst_q |=> !divrst_q || $past(soft_clr)); // R7
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_ctl2 |=> $stable(start_q)); // R8

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int YEAR_W = 16
) (
    input  fld_alarm_t [NUM_FLD-1:0]       alm,
    input  logic [NUM_FLD-1:0][VAL_W-1:0]  cnt,
    input  logic                           yen,
    input  logic [YEAR_W-1:0]              yalm,
    input  logic [YEAR_W-1:0]              ycnt,
    output logic                           match,
    output logic                           any_en
);
    logic [NUM_FLD-1:0] fld_ok;
    logic [NUM_FLD-1:0] fld_en;
    logic               yr_ok;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLD; gi++) begin : g_fld
            assign fld_en[gi] = alm[gi].en;
            assign fld_ok[gi] = !alm[gi].en || (alm[gi].val == cnt[gi]);
        end
    endgenerate

    assign yr_ok  = !yen || (yalm == ycnt);
    assign any_en = (|fld_en) || yen;
    assign match  = any_en && (&fld_ok) && yr_ok;

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic soft_clr,
    input  logic flag_clr,
    output logic flag
);
    logic flag_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            flag_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= match;
            if (match && !prev_q) flag_q <= 1'b1;
            else if (flag_clr)    flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    AST_FLAG_ON_NEW_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(match) && !$past(prev_q)); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_q && !flag_clr && !soft_clr |=> flag_q); // R4

endmodule

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl
    import rtc_alarm_pkg::*;
#(
    parameter int YEAR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [6:0]        cnt_sec,
    input  logic [6:0]        cnt_min,
    input  logic [6:0]        cnt_hour,
    input  logic [6:0]        cnt_wday,
    input  logic [6:0]        cnt_day,
    input  logic [6:0]        cnt_mon,
    input  logic [YEAR_W-1:0] cnt_year,
    output logic              run_en,
    output logic              div_rst,
    output logic              alarm_flag,
    output logic              alarm_irq
);
    fld_alarm_t [NUM_FLD-1:0]      alm;
    logic [NUM_FLD-1:0][VAL_W-1:0] cnt_arr;
    logic [YEAR_W-1:0]             yalm;
    logic yen, aie, soft_clr, flag_clr, match, any_en, flag;

    assign cnt_arr = {cnt_mon, cnt_day, cnt_wday, cnt_hour, cnt_min, cnt_sec};

    rtc_alarm_regs #(.YEAR_W(YEAR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .flag_in(flag), .bus_rdata(bus_rdata),
        .alm_o(alm), .yen_o(yen), .yalm_o(yalm), .start_o(run_en),
        .aie_o(aie), .divrst_o(div_rst), .soft_clr_o(soft_clr),
        .flag_clr_o(flag_clr)
    );

    rtc_alarm_match #(.YEAR_W(YEAR_W)) u_match (
        .alm(alm), .cnt(cnt_arr), .yen(yen), .yalm(yalm), .ycnt(cnt_year),
        .match(match), .any_en(any_en)
    );

    rtc_alarm_flag u_flag (
        .clk(clk), .rst(rst), .match(match), .soft_clr(soft_clr),
        .flag_clr(flag_clr), .flag(flag)
    );

    assign alarm_flag = flag;
    assign alarm_irq  = flag && aie;

    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(any_en)); // R3
    AST_DIVRST_AFTER_SRST: assert property (@(posedge clk) disable iff (rst)
        $rose(div_rst) |-> $past(bus_wr) && $past(bus_addr) == 4'd1); // R7

endmodule

// File: tb/rtc_alarm_ctl_tb.sv
module rtc_alarm_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [6:0]  cnt [6];
    logic [15:0] ycnt = '0;
    logic        run_en, div_rst, alarm_flag, alarm_irq;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    rtc_alarm_ctl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_sec(cnt[0]), .cnt_min(cnt[1]), .cnt_hour(cnt[2]),
        .cnt_wday(cnt[3]), .cnt_day(cnt[4]), .cnt_mon(cnt[5]),
        .cnt_year(ycnt), .run_en(run_en), .div_rst(div_rst),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    function automatic logic [6:0] aval(input int i);
        return 7'(8'h11 + i * 7);
    endfunction
    localparam logic [15:0] YVAL = 16'h2031;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic mismatch_all();
        for (int i = 0; i < 6; i++) cnt[i] = aval(i) ^ 7'h01;
        ycnt = YVAL ^ 16'h0001;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        mismatch_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), d);
            check("R10 reg reset", {8'h0, d}, 16'h0);
        end
        check("R10 outputs", {12'h0, run_en, div_rst, alarm_flag, alarm_irq}, 16'h0);

        // R1 R2 R3 R5 sweep over enable masks (bit 6 = year)
        for (int m = 0; m < 128; m++) begin
            logic [6:0] mask = 7'(m);
            logic [6:0] matched = '0;
            wr(4'd1, 8'h03);
            mismatch_all();
            for (int i = 0; i < 6; i++) wr(4'(2 + i), {mask[i], aval(i)});
            wr(4'd9, YVAL[7:0]);
            wr(4'd10, YVAL[15:8]);
            wr(4'd8, {mask[6], 7'h0});
            wr(4'd0, 8'h08);
            for (int s = 0; s < 7; s++) begin
                logic expf;
                @(negedge clk);
                if (s < 6) cnt[s] = aval(s); else ycnt = YVAL;
                matched[s] = 1'b1;
                rd(4'd0, d);
                expf = (mask != 0) && ((mask & ~matched) == 0);
                if (mask == 0) check("R3 no enable no flag", {15'h0, d[0]}, 16'h0);
                else           check("R1 R2 R5 enabled fields match", {15'h0, d[0]}, {15'h0, expf});
                check("R9 irq with enable", {15'h0, alarm_irq}, {15'h0, expf});
            end
        end

        // R5 year upper byte only wrong
        wr(4'd1, 8'h03);
        mismatch_all();
        wr(4'd9, YVAL[7:0]); wr(4'd10, YVAL[15:8]); wr(4'd8, 8'h80);
        @(negedge clk); ycnt = YVAL ^ 16'h0100;
        rd(4'd0, d);
        check("R5 year high byte compared", {15'h0, d[0]}, 16'h0);
        @(negedge clk); ycnt = YVAL;
        rd(4'd0, d);
        check("R5 year full match", {15'h0, d[0]}, 16'h1);

        // R4 sticky, write 1 no effect, no retrigger
        wr(4'd0, 8'h09);
        rd(4'd0, d);
        check("R4 write one keeps flag", {15'h0, d[0]}, 16'h1);
        wr(4'd0, 8'h08);
        repeat (3) @(negedge clk);
        rd(4'd0, d);
        check("R4 no retrigger while match holds", {15'h0, d[0]}, 16'h0);
        @(negedge clk); ycnt = YVAL ^ 16'h0001;
        @(negedge clk); ycnt = YVAL;
        rd(4'd0, d);
        check("R4 new match sets again", {15'h0, d[0]}, 16'h1);

        // R9 irq masked
        wr(4'd0, 8'h01);
        rd(4'd0, d);
        check("R9 irq masked flag kept", {14'h0, alarm_irq, d[0]}, 16'h1);
        wr(4'd0, 8'h09);
        check("R9 irq enabled", {15'h0, alarm_irq}, 16'h1);

        // R6 reserved bits
        wr(4'd8, 8'hFF);
        rd(4'd8, d);
        check("R6 reserved bits read zero", {8'h0, d}, 16'h0080);
        wr(4'd8, 8'h7F);
        rd(4'd8, d);
        check("R6 reserved write ignored", {8'h0, d}, 16'h0000);
        wr(4'd8, 8'h80);
        wr(4'd2, 8'hC5);

        // R7 soft reset
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h03;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 div_rst pulse", {15'h0, div_rst}, 16'h1);
        rd(4'd1, d);
        check("R7 reset bit reads zero", {8'h0, d}, 16'h0001);
        check("R7 div_rst one cycle", {15'h0, div_rst}, 16'h0);
        for (int a = 2; a < 11; a++) begin
            rd(4'(a), d);
            check("R7 alarm state cleared", {8'h0, d}, 16'h0);
        end
        check("R7 flag cleared", {15'h0, alarm_flag}, 16'h0);

        // R8 start bit
        wr(4'd1, 8'h00);
        check("R8 run_en halts", {15'h0, run_en}, 16'h0);
        repeat (4) @(negedge clk);
        wr(4'd0, 8'h00);
        check("R8 run_en stays halted", {15'h0, run_en}, 16'h0);
        wr(4'd1, 8'h01);
        check("R8 run_en runs", {15'h0, run_en}, 16'h1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule